// File: doc/BRIEF.md
# Write Status Read Responder

This block is the read side of a byte-wide, non-volatile memory that programs itself. On a read access it returns the byte stored at the addressed location, unless an internal programming cycle is running. While programming runs, a read returns a status byte instead. Bit 7 carries the inverted bit 7 of the byte last written, when the read address is that byte's address. Bit 6 changes state on every new read access. The other bits read as zero. When programming ends, reads return the stored data again. Software can therefore poll either bit to find out when the write has finished.

The chip-enable and output-enable strobes are active low and are sampled on the clock. A read is active when both are low. The block drives an 8-bit data word and a separate drive-enable, so the pad ring can put the bus in high impedance. The array is outside the block. The block presents the address to the array and takes back its read data in the same cycle. The write controller supplies the programming-busy flag and the last written address and data. All outputs are registered, so a change sampled at one rising edge appears after that edge.

Top module: `wsr_responder`

## Requirements
- R1: A read is active in a cycle where `ce_ni` and `oe_ni` are both sampled low. After that rising edge, `data_oe_o` is 1.
- R2: If `ce_ni` or `oe_ni` is sampled high, then after that edge `data_oe_o` is 0 and `data_o` is 0.
- R3: A read with `busy_i` low returns `array_rdata_i` for `array_addr_o`, and `array_addr_o` equals `addr_i`.
- R4: A read with `busy_i` high at address `last_addr_i` returns the inverse of `last_data_i[7]` on `data_o[7]`.
- R5: A read with `busy_i` high at any other address returns 0 on `data_o[7]`.
- R6: With `busy_i` high, the toggle bit `data_o[6]` inverts at each read start, meaning the first active cycle after an inactive one. A read held over several cycles keeps the bit steady.
- R7: The toggle bit is cleared in the cycle where `busy_i` is first seen high. If a read starts in that same cycle, the read shows 1.
- R8: During a read with `busy_i` high, `data_o[5:0]` is 0.
- R9: After `busy_i` falls, reads return the stored data again, including the true bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Read address |
| busy_i | input | 1 | Programming cycle in progress |
| last_addr_i | input | ADDR_W | Address of the last written byte |
| last_data_i | input | 8 | Last written byte |
| array_rdata_i | input | 8 | Array read data for `array_addr_o` |
| array_addr_o | output | ADDR_W | Address presented to the array |
| data_o | output | 8 | Read data or status byte |
| data_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The bench builds the block with `ADDR_W = 4`. With 16 locations, every address is read both with and without a programming cycle running. Each address is also read with both values of the last written bit 7, once at the matching address and across all non-matching ones. The small space also leaves room for:
- long runs of toggle reads;
- held reads;
- a programming cycle restarted after an odd number of reads;
- a read that starts in the same cycle as busy.

The bench models the expected toggle state from the strobe sequence alone.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam logic        TOG_INIT = 1'b0;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/wsr_access_detect.sv
module wsr_access_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic busy_i,
  output logic rd_en_o,
  output logic rd_start_o,
  output logic busy_rise_o
);
  logic rd_q, busy_q;

  assign rd_en_o     = ~ce_ni & ~oe_ni;
  assign rd_start_o  = rd_en_o & ~rd_q;
  assign busy_rise_o = busy_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      rd_q   <= rd_en_o;
      busy_q <= busy_i;
    end
  end

  // A held read must not count as a new access
  assert_held_read_no_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_start_o);
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic busy_rise_i,
  input  logic rd_start_i,
  output logic tog_d_o
);
  import wsr_pkg::*;

  logic tog_q;

  always_comb begin
    tog_d_o = tog_q;
    if (busy_rise_i)            tog_d_o = TOG_INIT ^ rd_start_i;
    else if (busy_i && rd_start_i) tog_d_o = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= TOG_INIT;
    else         tog_q <= tog_d_o;
  end

  assert_tog_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_start_i && !busy_rise_i) |=> (tog_q != $past(tog_q)));
  assert_tog_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i) |=> $stable(tog_q));
  assert_tog_init_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_rise_i |=> (tog_q == (TOG_INIT ^ $past(rd_start_i))));
endmodule

// File: rtl/wsr_out_mux.sv
module wsr_out_mux #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  wsr_pkg::byte_t    last_data_i,
  input  wsr_pkg::byte_t    array_rdata_i,
  input  logic              tog_i,
  output wsr_pkg::byte_t    data_o,
  output logic              data_oe_o
);
  import wsr_pkg::*;

  byte_t status_b, data_d, data_q;
  logic  oe_q, addr_hit;

  assign addr_hit = (addr_i == last_addr_i);

  always_comb begin
    status_b           = '0;
    status_b[POLL_BIT] = addr_hit & ~last_data_i[POLL_BIT];
    status_b[TOG_BIT]  = tog_i;
  end

  always_comb begin
    if (!rd_en_i)    data_d = '0;
    else if (busy_i) data_d = status_b;
    else             data_d = array_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      oe_q   <= rd_en_i;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;

  assert_read_drives_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> data_oe_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!data_oe_o && data_o == '0));
  assert_array_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !busy_i) |=> (data_o == $past(array_rdata_i)));
  assert_poll_inv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i && addr_hit) |=> (data_o[POLL_BIT] == ~$past(last_data_i[POLL_BIT])));
  assert_poll_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i && !addr_hit) |=> !data_o[POLL_BIT]);
  assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i) |=> (data_o[5:0] == '0));
endmodule

// File: rtl/wsr_responder.sv
module wsr_responder #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [7:0]        last_data_i,
  input  logic [7:0]        array_rdata_i,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  logic rd_en, rd_start, busy_rise, tog_d;

  assign array_addr_o = addr_i;

  wsr_access_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .busy_i     (busy_i),
    .rd_en_o    (rd_en),
    .rd_start_o (rd_start),
    .busy_rise_o(busy_rise)
  );

  wsr_toggle u_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_i),
    .busy_rise_i(busy_rise),
    .rd_start_i (rd_start),
    .tog_d_o    (tog_d)
  );

  wsr_out_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en),
    .busy_i       (busy_i),
    .addr_i       (addr_i),
    .last_addr_i  (last_addr_i),
    .last_data_i  (last_data_i),
    .array_rdata_i(array_rdata_i),
    .tog_i        (tog_d),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o)
  );

  // Stored data returns once busy drops
  assert_true_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !ce_ni && !oe_ni) |=> (data_o == $past(array_rdata_i)));
endmodule

// File: tb/sim_wsr_responder.sv
module sim_wsr_responder;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr = '0, last_addr = '0;
  logic [7:0]    last_data = '0, arr_rdata;
  logic [AW-1:0] arr_addr;
  logic [7:0]    dout;
  logic          dout_oe;

  int n_chk = 0, n_bad = 0;
  logic m_prev_rd = 1'b0, m_prev_busy = 1'b0, m_tog = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] arr_f(input logic [AW-1:0] a);
    return 8'(a * 37 + 5) ^ 8'h80;
  endfunction
  assign arr_rdata = arr_f(arr_addr);

  wsr_responder #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .addr_i(addr),
    .busy_i(busy), .last_addr_i(last_addr), .last_data_i(last_data),
    .array_rdata_i(arr_rdata), .array_addr_o(arr_addr),
    .data_o(dout), .data_oe_o(dout_oe)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, check after the following posedge.
  task automatic step(input logic ce, input logic oe, input logic [AW-1:0] a,
                      input logic b, input string req);
    logic rd, st, br;
    logic [7:0] e;
    ce_n = ce; oe_n = oe; addr = a; busy = b;
    rd = ~ce & ~oe;
    st = rd & ~m_prev_rd;
    br = b & ~m_prev_busy;
    if (br) m_tog = st;
    else if (b && st) m_tog = ~m_tog;
    m_prev_rd = rd; m_prev_busy = b;
    if (!rd) e = 8'h00;
    else if (b) e = {(a == last_addr) & ~last_data[7], m_tog, 6'b0};
    else e = arr_f(a);
    @(negedge clk);
    check(req, {dout_oe, dout}, {rd, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", {dout_oe, dout}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R3: idle reads over every address, with gaps between them
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 1'b0, AW'(a), 1'b0, "R1_R3 idle read");
      step(1'b1, 1'b1, AW'(a), 1'b0, "R2 gap");
    end
    // R2: only one of the two strobes low
    step(1'b1, 1'b0, 4'd3, 1'b0, "R2 ce high");
    step(1'b0, 1'b1, 4'd3, 1'b0, "R2 oe high");
    // R4 R5 R6 R8: status sweep
    last_addr = 4'd9;
    for (int d = 0; d < 2; d++) begin
      last_data = d[0] ? 8'h95 : 8'h2A;
      step(1'b1, 1'b1, 4'd0, 1'b1, "R7 busy start");
      for (int a = 0; a < 16; a++) begin
        step(1'b0, 1'b0, AW'(a), 1'b1, "R4_R5_R6_R8 status read");
        step(1'b0, 1'b0, AW'(a), 1'b1, "R6 held read");
        step(1'b1, 1'b1, AW'(a), 1'b1, "R2 busy gap");
        step(1'b1, 1'b0, AW'(a), 1'b1, "R6 non-read no flip");
      end
      step(1'b0, 1'b0, 4'd9, 1'b1, "R4 poll hit");
      step(1'b1, 1'b1, 4'd9, 1'b0, "R9 busy end");
      step(1'b0, 1'b0, 4'd9, 1'b0, "R9 true data");
      step(1'b1, 1'b1, 4'd9, 1'b0, "R2 gap");
    end
    // R7: restart after an odd number of toggle reads
    step(1'b1, 1'b1, 4'd1, 1'b1, "R7 start");
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 4'd1, 1'b1, "R6 read");
      step(1'b1, 1'b1, 4'd1, 1'b1, "R2 gap");
    end
    step(1'b1, 1'b1, 4'd1, 1'b0, "R9 end");
    step(1'b1, 1'b1, 4'd1, 1'b1, "R7 restart");
    step(1'b0, 1'b0, 4'd1, 1'b1, "R7 first read shows 1");
    check("R7 explicit", {8'h0, dout[6]}, 9'h001);
    step(1'b1, 1'b1, 4'd1, 1'b0, "R9 end");
    // R7: read start in the same cycle busy rises
    step(1'b0, 1'b0, 4'd2, 1'b1, "R7 coincident start");
    step(1'b0, 1'b0, 4'd2, 1'b1, "R6 coincident held");
    step(1'b1, 1'b1, 4'd2, 1'b0, "R9 end");
    // R7: read already active when busy rises
    step(1'b0, 1'b0, 4'd9, 1'b0, "R3 pre-busy read");
    step(1'b0, 1'b0, 4'd9, 1'b1, "R7 busy under held read");
    step(1'b0, 1'b0, 4'd9, 1'b0, "R9 held read after busy");
    step(1'b1, 1'b1, 4'd0, 1'b0, "R2 final");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule